// File: doc/BRIEF.md
# NVRAM Region Checksum Engine

This block walks a region of a byte-wide NVRAM and reduces it to a 16-bit checksum. A start pulse captures a start address, a byte count and an optional store-back request. The engine then reads the memory one byte per cycle through a synchronous read port with a fixed one-cycle latency. It folds the bytes into a running 16-bit value and raises a one-cycle done pulse when the checksum is final. If store-back was requested, the result is also written into the memory as two bytes, high byte first.

Words are big-endian pairs of neighbouring bytes. The read address moves forward by one byte per word, so each word shares one byte with the word before it. The even part of the count sets how many words are folded. For an odd count, one last fold uses the byte just past the even part as the high half of a word whose low half is zero. A typical use checksums a 248-byte parameter header and stores the result a few bytes past it.

The controller has six states. `S_IDLE` waits for a start. `S_RUN` streams reads and folds the returning bytes. `S_TAIL` applies the odd-byte fold. `S_WR_HI` and `S_WR_LO` store the result. `S_FIN` gives the done pulse. The transitions are:
- `S_IDLE` to `S_RUN` on a start pulse with a nonzero count.
- `S_IDLE` to `S_WR_HI` or `S_FIN` on a start pulse with a zero count.
- `S_RUN` to `S_TAIL` once every read has returned, if the count is odd.
- `S_RUN`, or `S_TAIL`, to `S_WR_HI` if store-back was requested, otherwise to `S_FIN`.
- `S_WR_HI` to `S_WR_LO`, then `S_WR_LO` to `S_FIN`.
- `S_FIN` back to `S_IDLE`.

Top module: `nvsum_engine`

## Requirements
- R1: After reset, `busy` and `done` are 0, `sum` is 0xFFFF, and neither memory enable is asserted.
- R2: An accepted start sets the accumulator to 0xFFFF. Each fold of accumulator p with word v gives the following result, with all values truncated to 16 bits:
  - d = p XOR v, a = d[3:0], b = d[7:4] XOR a.
  - The result is (p>>8) XOR (a<<3) XOR (a<<8) XOR b XOR (b<<7) XOR (b<<12).
- R3: For start s and count n, let E be n with bit 0 cleared. For k = 0 to E-1, fold k uses the word (byte[s+k]<<8) | byte[s+k+1], so successive words overlap by one byte.
- R4: When n is odd, one more fold follows, using the word byte[s+E]<<8 (low 8 bits zero).
- R5: For n > 0, the engine issues exactly E+1 reads, to s, s+1, ..., s+E, one per cycle. Read data is taken the cycle after its enable.
- R6: A count of zero finishes with `sum` = 0xFFFF and issues no reads.
- R7: `busy` is 1 from the cycle after an accepted start through the cycle of `done`, and 0 after it. `done` lasts one cycle.
- R8: A start pulse while `busy` is 1 is ignored. The running job's result and read count are unchanged.
- R9: If `wb_en` is 1 at the start, the engine writes sum[15:8] to `wb_addr`, then sum[7:0] to `wb_addr`+1, in consecutive cycles before `done`. If `wb_en` is 0, it makes no writes.
- R10: While idle and without a start, `sum` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start pulse |
| start_addr | input | AW | First byte address of the region |
| byte_cnt | input | CW | Number of bytes in the region |
| wb_en | input | 1 | Store the result back into memory |
| wb_addr | input | AW | Address for the high result byte |
| mem_rd_en | output | 1 | Read enable |
| mem_rd_addr | output | AW | Read address |
| mem_rd_data | input | 8 | Read data, valid the cycle after the enable |
| mem_wr_en | output | 1 | Write enable |
| mem_wr_addr | output | AW | Write address |
| mem_wr_data | output | 8 | Write data |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| sum | output | 16 | Checksum result |

## Verification
The assertions assume that the memory answers every read exactly one cycle later, and that a region plus its one-byte overlap never wraps past the top of the address space. They also assume that a store-back target does not overlap the bytes being read. The bench keeps to these conditions by construction:
- Its memory model is a registered array.
- Random start addresses and counts are kept low in the space.
- Random store-back targets are drawn from the upper part of the space.
- The directed header case places its result outside the summed range.

// File: rtl/nvsum_pkg.sv
package nvsum_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RUN,
        S_TAIL,
        S_WR_HI,
        S_WR_LO,
        S_FIN
    } nvsum_state_e;

    localparam logic [15:0] SUM_SEED = 16'hFFFF;

endpackage

// File: rtl/nvsum_fold.sv
// One nibble-folding step: accumulator p, big-endian word {hi, lo}.
module nvsum_fold (
    input  logic [15:0] p,
    input  logic [7:0]  hi,
    input  logic [7:0]  lo,
    output logic [15:0] q
);
    logic [15:0] d;
    logic [3:0]  a;
    logic [3:0]  b;

    always_comb begin
        d = p ^ {hi, lo};
        a = d[3:0];
        b = d[7:4] ^ a;
        q = {8'h00, p[15:8]}
          ^ {9'b0, a, 3'b0}
          ^ {4'b0, a, 8'b0}
          ^ {12'b0, b}
          ^ {5'b0, b, 7'b0}
          ^ {b, 12'b0};
    end
endmodule

// File: rtl/nvsum_fetch.sv
// Byte address walker: issues one read per cycle until the loaded number is used up.
module nvsum_fetch #(
    parameter int AW = 13,
    parameter int NW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [NW-1:0] load_num,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          vld,
    output logic          pending
);
    logic [AW-1:0] ptr;
    logic [NW-1:0] left;

    assign rd_en   = (left != '0);
    assign rd_addr = ptr;
    assign pending = rd_en | vld;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr  <= '0;
            left <= '0;
            vld  <= 1'b0;
        end else begin
            vld <= rd_en;
            if (load) begin
                ptr  <= load_addr;
                left <= load_num;
            end else if (rd_en) begin
                ptr  <= ptr + 1'b1;
                left <= left - 1'b1;
            end
        end
    end
endmodule

// File: rtl/nvsum_engine.sv
module nvsum_engine #(
    parameter int AW = 13,
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [AW-1:0] start_addr,
    input  logic [CW-1:0] byte_cnt,
    input  logic          wb_en,
    input  logic [AW-1:0] wb_addr,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [7:0]    mem_rd_data,
    output logic          mem_wr_en,
    output logic [AW-1:0] mem_wr_addr,
    output logic [7:0]    mem_wr_data,
    output logic          busy,
    output logic          done,
    output logic [15:0]   sum
);
    import nvsum_pkg::*;

    localparam int NW = CW + 1;

    nvsum_state_e  state, state_nx;
    logic [15:0]   acc;
    logic [7:0]    prev;
    logic          have_prev;
    logic          odd_q;
    logic          wb_q;
    logic [AW-1:0] wba_q;

    logic          accept;
    logic          f_load;
    logic [NW-1:0] f_num;
    logic          f_vld;
    logic          f_pending;
    logic [7:0]    fold_lo;
    logic [15:0]   fold_q;

    assign accept = (state == S_IDLE) && go;
    assign f_load = accept;
    // Nonzero count reads the even part plus one overlap/tail byte.
    assign f_num  = (byte_cnt == '0) ? '0
                  : ({1'b0, byte_cnt} & ~{{(NW-1){1'b0}}, 1'b1}) + 1'b1;

    nvsum_fetch #(.AW(AW), .NW(NW)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (f_load),
        .load_addr (start_addr),
        .load_num  (f_num),
        .rd_en     (mem_rd_en),
        .rd_addr   (mem_rd_addr),
        .vld       (f_vld),
        .pending   (f_pending)
    );

    assign fold_lo = (state == S_TAIL) ? 8'h00 : mem_rd_data;

    nvsum_fold u_fold (
        .p  (acc),
        .hi (prev),
        .lo (fold_lo),
        .q  (fold_q)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (go) begin
                if (byte_cnt != '0) state_nx = S_RUN;
                else if (wb_en)     state_nx = S_WR_HI;
                else                state_nx = S_FIN;
            end
            S_RUN: if (!f_pending) begin
                if (odd_q)     state_nx = S_TAIL;
                else if (wb_q) state_nx = S_WR_HI;
                else           state_nx = S_FIN;
            end
            S_TAIL:  state_nx = wb_q ? S_WR_HI : S_FIN;
            S_WR_HI: state_nx = S_WR_LO;
            S_WR_LO: state_nx = S_FIN;
            S_FIN:   state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc       <= SUM_SEED;
            prev      <= 8'h00;
            have_prev <= 1'b0;
            odd_q     <= 1'b0;
            wb_q      <= 1'b0;
            wba_q     <= '0;
        end else if (accept) begin
            acc       <= SUM_SEED;
            have_prev <= 1'b0;
            odd_q     <= byte_cnt[0];
            wb_q      <= wb_en;
            wba_q     <= wb_addr;
        end else if (state == S_RUN && f_vld) begin
            if (have_prev) acc <= fold_q;
            prev      <= mem_rd_data;
            have_prev <= 1'b1;
        end else if (state == S_TAIL) begin
            acc <= fold_q;
        end
    end

    // Outputs
    always_comb begin
        busy        = (state != S_IDLE);
        done        = (state == S_FIN);
        sum         = acc;
        mem_wr_en   = 1'b0;
        mem_wr_addr = wba_q;
        mem_wr_data = acc[15:8];
        unique case (state)
            S_WR_HI: begin
                mem_wr_en = 1'b1;
            end
            S_WR_LO: begin
                mem_wr_en   = 1'b1;
                mem_wr_addr = wba_q + 1'b1;
                mem_wr_data = acc[7:0];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/nvsum_engine_chk.sv
module nvsum_engine_chk #(
    parameter int AW = 13,
    parameter int CW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          go,
    input logic          mem_rd_en,
    input logic [AW-1:0] mem_rd_addr,
    input logic          mem_wr_en,
    input logic [AW-1:0] mem_wr_addr,
    input logic [7:0]    mem_wr_data,
    input logic          busy,
    input logic          done,
    input logic [15:0]   sum
);
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_busy_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    p_rd_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> busy);

    p_rd_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> (!mem_rd_en || mem_rd_addr == $past(mem_rd_addr) + 1'b1));

    p_wr_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_en) |=> (mem_wr_en && mem_wr_addr == $past(mem_wr_addr) + 1'b1));

    p_wr_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_en) |-> (mem_wr_data == sum[15:8]));

    p_seed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && go) |=> (sum == 16'hFFFF));

    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !go) |=> $stable(sum));
endmodule

bind nvsum_engine nvsum_engine_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .go          (go),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .mem_wr_en   (mem_wr_en),
    .mem_wr_addr (mem_wr_addr),
    .mem_wr_data (mem_wr_data),
    .busy        (busy),
    .done        (done),
    .sum         (sum)
);

// File: tb/nvsum_engine_test.sv
module nvsum_engine_test;
    localparam int AW = 10;
    localparam int CW = 10;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          go = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [CW-1:0] byte_cnt = '0;
    logic          wb_en = 1'b0;
    logic [AW-1:0] wb_addr = '0;
    logic          mem_rd_en;
    logic [AW-1:0] mem_rd_addr;
    logic [7:0]    mem_rd_data;
    logic          mem_wr_en;
    logic [AW-1:0] mem_wr_addr;
    logic [7:0]    mem_wr_data;
    logic          busy;
    logic          done;
    logic [15:0]   sum;

    logic [7:0] mem [DEPTH];
    int rd_cnt = 0;
    int wr_cnt = 0;
    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    nvsum_engine #(.AW(AW), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .go(go), .start_addr(start_addr),
        .byte_cnt(byte_cnt), .wb_en(wb_en), .wb_addr(wb_addr),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .busy(busy), .done(done), .sum(sum)
    );

    // Memory model: registered read, one cycle of latency
    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_data <= mem[mem_rd_addr];
            rd_cnt <= rd_cnt + 1;
        end
        if (mem_wr_en) begin
            mem[mem_wr_addr] <= mem_wr_data;
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_fold(input logic [15:0] p, input logic [15:0] v);
        logic [15:0] d, a, b, t;
        d = p ^ v;
        a = d & 16'h000F;
        b = ((d >> 4) & 16'h000F) ^ a;
        t = p >> 8;
        t = t ^ ((a << 3) | (a << 8));
        t = t ^ (b | (b << 7) | (b << 12));
        return t;
    endfunction

    function automatic logic [15:0] ref_sum(input int base, input int len);
        logic [15:0] c;
        int e;
        c = 16'hFFFF;
        e = len & ~1;
        for (int i = 0; i < e; i++)
            c = ref_fold(c, {mem[base+i], mem[base+i+1]});
        if (len % 2 == 1)
            c = ref_fold(c, {mem[base+e], 8'h00});
        return c;
    endfunction

    task automatic run_job(input int base, input int len, input bit wb, input int wba,
                           input bit poke);
        logic [15:0] exp;
        int exp_rd, r0, w0, cyc;
        bit busy_ok;
        string tag;
        exp    = ref_sum(base, len);
        exp_rd = (len == 0) ? 0 : (len & ~1) + 1;
        tag    = (len == 0) ? "R6" : (len == 2) ? "R2" : (len % 2 == 1) ? "R4" : "R3";
        r0 = rd_cnt;
        w0 = wr_cnt;
        @(negedge clk);
        start_addr = AW'(base);
        byte_cnt   = CW'(len);
        wb_en      = wb;
        wb_addr    = AW'(wba);
        go         = 1'b1;
        @(negedge clk);
        go = 1'b0;
        cyc = 0;
        busy_ok = 1'b1;
        while (!done && cyc < 5000) begin
            if (!busy) busy_ok = 1'b0;
            // R8: a second start while busy must be ignored
            if (poke && cyc == 1) begin
                start_addr = AW'(base + 9);
                byte_cnt   = CW'(len + 3);
                wb_en      = ~wb;
                go         = 1'b1;
            end else begin
                go = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        go = 1'b0;
        check(cyc < 5000, "watchdog", cyc, 5000);
        check(sum == exp, tag, sum, exp);
        check(rd_cnt - r0 == exp_rd, "R5 reads", rd_cnt - r0, exp_rd);
        check(busy_ok, "R7 busy during job", busy_ok, 1);
        if (poke) check(sum == exp && rd_cnt - r0 == exp_rd, "R8 ignored start", sum, exp);
        check(wr_cnt - w0 == (wb ? 2 : 0), "R9 write count", wr_cnt - w0, wb ? 2 : 0);
        if (wb) begin
            check(mem[wba] == exp[15:8], "R9 high byte", mem[wba], exp[15:8]);
            check(mem[wba+1] == exp[7:0], "R9 low byte", mem[wba+1], exp[7:0]);
        end
        @(negedge clk);
        check(!busy && !done, "R7 after done", {busy, done}, 0);
        repeat (3) @(negedge clk);
        check(sum == exp, "R10 hold", sum, exp);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'($urandom);
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(done == 1'b0, "R1 done", done, 0);
        check(sum == 16'hFFFF, "R1 sum", sum, 16'hFFFF);
        check(!mem_rd_en && !mem_wr_en, "R1 enables", {mem_rd_en, mem_wr_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corner cases
        run_job(10, 0, 1'b0, 0, 1'b0);      // R6 zero count
        run_job(10, 0, 1'b1, 950, 1'b0);    // R6 with store-back of seed
        run_job(20, 1, 1'b0, 0, 1'b0);      // R4 single byte
        mem[40] = 8'h12; mem[41] = 8'h34; mem[42] = 8'h56;
        run_job(40, 2, 1'b0, 0, 1'b0);      // R2 one fold
        run_job(40, 3, 1'b0, 0, 1'b0);      // R4 odd tail
        run_job(100, 37, 1'b0, 0, 1'b1);    // R8 start while busy
        // Header-style use: 248 bytes from 0, result at 0xFC
        run_job(0, 248, 1'b1, 252, 1'b0);   // R9
        run_job(0, 248, 1'b0, 0, 1'b0);     // R3, region unaffected by store-back

        // Random jobs
        for (int j = 0; j < 20; j++) begin
            int b, n, wa;
            bit w;
            b  = $urandom_range(0, 500);
            n  = $urandom_range(0, 300);
            w  = 1'($urandom);
            wa = $urandom_range(900, 1000);
            run_job(b, n, w, wa, j % 5 == 0);
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule